// File: doc/BRIEF.md
# I2C Master Command-List Sequencer

This block is the control layer of an I2C master. Before a transfer, software loads a small queue of command words. Each word names one bus primitive, gives a byte count and sets the acknowledge handling. A pulse on `go` starts the sequencer at entry 0 and runs the entries in order. Write entries take bytes from a transmit FIFO. Read entries place received bytes in a receive FIFO. The sequencer compares acknowledge bits with the expected level and sets a done flag in each word it retires. Four sticky status bits record completion, acknowledge error, timeout and arbitration loss. An enable mask combines them into one interrupt line.

Bit timing on SCL and SDA belongs to a separate bit engine. The two blocks talk over a request/done handshake: `prim_req`, `prim_op` and `prim_wdata` go out, and the engine returns `prim_done`, the received byte, the sampled acknowledge level, an arbitration-lost flag and a `bus_stall` level.

The controller has five states. In IDLE it waits for `go`. FETCH decodes the current word. A start or stop entry moves to XFER. A write or read entry with a nonzero count moves to LOAD, and one with a zero count moves to RETIRE. End-type opcodes return to IDLE. LOAD waits until the FIFO can supply or accept a byte, then moves to XFER. XFER holds the request until the engine answers. From there it goes to RETIRE when the entry is finished, back to LOAD when bytes remain, or to IDLE after a stop, an error, arbitration loss or a timeout. RETIRE sets the done flag and moves to FETCH for the next entry. After the last queue entry it returns to IDLE with completion set.

Top module: `i2cseq_top`

## Requirements
- R1: After reset, `busy`, `bus_busy`, `int_raw`, `irq` and `prim_req` are all 0, `rx_empty` is 1 and `tx_full` is 0.
- R2: A `go` pulse while idle raises `busy` one clock edge later and starts execution at entry 0. A `go` pulse while busy has no effect: no second start primitive is issued.
- R3: Command word layout: byte count in bits 7:0, ack-check enable in bit 8, expected ack level in bit 9, ack level to send in bit 10, opcode in bits 13:11 (0 repeated start, 1 write, 2 read, 3 stop, 4 end), done flag in bit 31. `prim_op` carries the opcode code of the primitive being issued.
- R4: A write entry issues one write primitive per byte and sends the TX FIFO bytes in push order. A count of 0 retires the entry without issuing a primitive. An empty TX FIFO holds the sequencer with `prim_req` low until a byte arrives. The request, opcode and data stay steady until `prim_done`.
- R5: On a write with ack-check enabled, a received ack level that differs from the expected level sets `int_raw[1]` and halts the sequencer. The entry's done flag stays 0. With ack-check disabled, a NACK is ignored and the entry completes.
- R6: A read entry issues one read primitive per byte and drives `prim_ack_out` with the entry's ack-to-send bit. Received bytes enter the RX FIFO in arrival order.
- R7: An end entry (opcodes 4 to 7) sets its done flag, sets `int_raw[0]` and halts without issuing a stop primitive. The next `go` starts again from entry 0.
- R8: Every entry that retires normally has bit 31 set when read back.
- R9: A completed start primitive sets `bus_busy`. A completed stop primitive clears `bus_busy`, marks the entry done, sets `int_raw[0]` and halts.
- R10: A timeout sets `int_raw[2]` and halts. It fires at the edge that completes `to_limit` consecutive stalled cycles. A cycle is stalled when `bus_stall` is high during a request, or when a FIFO holds the sequencer in LOAD. A `to_limit` of 0 disables the timeout.
- R11: `prim_done` together with `prim_arb_lost` sets `int_raw[3]` and halts the sequencer, leaving the entry's done flag at 0.
- R12: Status bits are sticky. Writing a 1 to `int_clr[i]` clears bit i at the next edge. `irq` is the OR of `int_raw & int_ena`.
- R13: A pulse on `tx_flush` empties the TX FIFO and a pulse on `rx_flush` empties the RX FIFO. Neither pulse changes the other FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_we | input | 1 | Queue write strobe |
| cmd_waddr | input | QAW | Queue write index |
| cmd_wdata | input | 32 | Queue write word |
| cmd_raddr | input | QAW | Queue readback index |
| cmd_rdata | output | 32 | Queue readback word, including the done flag |
| go | input | 1 | Start pulse |
| busy | output | 1 | Sequencer running |
| bus_busy | output | 1 | Bus held between start and stop |
| tx_push | input | 1 | Push a byte into the TX FIFO |
| tx_data | input | 8 | Byte to push |
| tx_full | output | 1 | TX FIFO full |
| rx_pop | input | 1 | Pop a byte from the RX FIFO |
| rx_data | output | 8 | Head byte of the RX FIFO |
| rx_empty | output | 1 | RX FIFO empty |
| tx_flush | input | 1 | TX FIFO flush |
| rx_flush | input | 1 | RX FIFO flush |
| to_limit | input | TO_W | Stall-cycle limit (0 disables the timeout) |
| int_ena | input | 4 | Status enable mask |
| int_clr | input | 4 | Write-one-to-clear for the status bits |
| int_raw | output | 4 | Sticky status: 0 complete, 1 ack error, 2 timeout, 3 arbitration lost |
| irq | output | 1 | Interrupt |
| prim_req | output | 1 | Primitive request to the bit engine |
| prim_op | output | 3 | Primitive opcode |
| prim_wdata | output | 8 | Byte to transmit |
| prim_ack_out | output | 1 | Ack level to drive after a read byte |
| prim_done | input | 1 | Primitive finished (one cycle) |
| prim_rdata | input | 8 | Received byte |
| prim_ack_in | input | 1 | Sampled ack level (0 = ACK) |
| prim_arb_lost | input | 1 | Arbitration lost during the primitive |
| bus_stall | input | 1 | Bus held stalled by the far end |

## Verification
Each result has a fixed due cycle. `busy` rises at the first edge after `go`. A status bit appears at the same edge the state machine leaves XFER, or at the edge after a `int_clr` write. The timeout bit first appears `to_limit`+2 edges after the `go` edge, because FETCH and the move into XFER come first. The bench drives every input at a falling edge and samples at falling edges. It counts edges exactly for `busy`, the timeout and clearing. For whole transfers it waits for `busy` to fall before comparing the logged primitives, the FIFO contents and the done flags.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [2:0] {
        OP_RSTART = 3'd0,
        OP_WRITE  = 3'd1,
        OP_READ   = 3'd2,
        OP_STOP   = 3'd3,
        OP_END    = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_XFER,
        ST_RETIRE
    } state_e;

    localparam int DONE_BIT = 31;
    localparam int NSTAT    = 4;
    localparam int S_CMPL   = 0;
    localparam int S_ACKERR = 1;
    localparam int S_TOUT   = 2;
    localparam int S_ARB    = 3;

    typedef struct packed {
        logic [7:0] cnt;
        logic       ack_en;
        logic       ack_exp;
        logic       ack_val;
        logic [2:0] op;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [31:0] w);
        cmd_t c;
        c.cnt     = w[7:0];
        c.ack_en  = w[8];
        c.ack_exp = w[9];
        c.ack_val = w[10];
        c.op      = w[13:11];
        return c;
    endfunction

endpackage

// File: rtl/i2cseq_fifo.sv
module i2cseq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic push_ok, pop_ok;

    assign empty   = (cnt == '0);
    assign full    = (cnt == (AW+1)'(DEPTH));
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign rdata   = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wdata;
    end
endmodule

// File: rtl/i2cseq_cmdq.sv
module i2cseq_cmdq #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_we,
    input  logic [AW-1:0] sw_waddr,
    input  logic [31:0]   sw_wdata,
    input  logic [AW-1:0] sw_raddr,
    output logic [31:0]   sw_rdata,
    input  logic [AW-1:0] seq_raddr,
    output logic [31:0]   seq_rdata,
    input  logic          done_set,
    input  logic [AW-1:0] done_addr
);
    import i2cseq_pkg::*;

    logic [31:0] q [DEPTH];

    assign sw_rdata  = q[sw_raddr];
    assign seq_rdata = q[seq_raddr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) q[i] <= '0;
        end else begin
            if (sw_we)    q[sw_waddr] <= sw_wdata;
            if (done_set) q[done_addr][DONE_BIT] <= 1'b1;
        end
    end
endmodule

// File: rtl/i2cseq_irq.sv
module i2cseq_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] ena,
    output logic [N-1:0] raw,
    output logic         irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw <= '0;
        else        raw <= (raw & ~clr) | set;
    end

    assign irq = |(raw & ena);
endmodule

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl #(
    parameter int QDEPTH = 16,
    parameter int TO_W   = 16,
    localparam int QAW   = $clog2(QDEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go,
    output logic                      busy,
    output logic                      bus_busy,
    input  logic [31:0]               cmd_word,
    output logic [QAW-1:0]            ptr,
    output logic                      done_set,
    input  logic                      tx_empty,
    input  logic [7:0]                tx_data,
    output logic                      tx_pop,
    input  logic                      rx_full,
    output logic                      rx_push,
    output logic [7:0]                rx_wdata,
    input  logic [TO_W-1:0]           to_limit,
    output logic [i2cseq_pkg::NSTAT-1:0] st_set,
    output logic                      prim_req,
    output logic [2:0]                prim_op,
    output logic [7:0]                prim_wdata,
    output logic                      prim_ack_out,
    input  logic                      prim_done,
    input  logic [7:0]                prim_rdata,
    input  logic                      prim_ack_in,
    input  logic                      prim_arb_lost,
    input  logic                      bus_stall
);
    import i2cseq_pkg::*;

    state_e        state, nxt;
    cmd_t          cur, fetched;
    logic [7:0]    rem, wbyte;
    logic [TO_W-1:0] stall_cnt;
    logic          bbusy;
    logic          blocked, stalled, tout_hit, xfer_end, ack_bad, last_byte;
    logic          fetch_halt, ptr_last, ok_end;

    assign fetched    = decode_cmd(cmd_word);
    assign fetch_halt = (fetched.op > 3'(OP_STOP));
    assign blocked    = (cur.op == OP_WRITE) ? tx_empty : rx_full;
    assign stalled    = ((state == ST_LOAD) && blocked) ||
                        ((state == ST_XFER) && bus_stall);
    assign tout_hit   = (to_limit != '0) && stalled &&
                        (({1'b0, stall_cnt} + 1'b1) >= {1'b0, to_limit});
    assign xfer_end   = (state == ST_XFER) && prim_done && !tout_hit;
    assign ok_end     = xfer_end && !prim_arb_lost;
    assign ack_bad    = (cur.op == OP_WRITE) && cur.ack_en &&
                        (prim_ack_in != cur.ack_exp);
    assign last_byte  = (rem == 8'd1);
    assign ptr_last   = (ptr == QAW'(QDEPTH - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (go) nxt = ST_FETCH;
            ST_FETCH: begin
                case (fetched.op)
                    OP_RSTART, OP_STOP: nxt = ST_XFER;
                    OP_WRITE, OP_READ:  nxt = (fetched.cnt == 8'd0) ? ST_RETIRE : ST_LOAD;
                    default:            nxt = ST_IDLE;
                endcase
            end
            ST_LOAD: begin
                if (tout_hit)      nxt = ST_IDLE;
                else if (!blocked) nxt = ST_XFER;
            end
            ST_XFER: begin
                if (tout_hit) nxt = ST_IDLE;
                else if (prim_done) begin
                    if (prim_arb_lost) nxt = ST_IDLE;
                    else begin
                        case (cur.op)
                            OP_RSTART: nxt = ST_RETIRE;
                            OP_WRITE:  nxt = ack_bad ? ST_IDLE :
                                             (last_byte ? ST_RETIRE : ST_LOAD);
                            OP_READ:   nxt = last_byte ? ST_RETIRE : ST_LOAD;
                            default:   nxt = ST_IDLE;
                        endcase
                    end
                end
            end
            ST_RETIRE: nxt = ptr_last ? ST_IDLE : ST_FETCH;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr       <= '0;
            cur       <= '0;
            rem       <= '0;
            wbyte     <= '0;
            stall_cnt <= '0;
            bbusy     <= 1'b0;
        end else begin
            stall_cnt <= stalled ? stall_cnt + 1'b1 : '0;
            if (state == ST_IDLE && go) ptr <= '0;
            if (state == ST_FETCH) begin
                cur <= fetched;
                rem <= fetched.cnt;
            end
            if (tx_pop) wbyte <= tx_data;
            if (ok_end) begin
                if (cur.op == OP_WRITE || cur.op == OP_READ) rem <= rem - 8'd1;
                if (cur.op == OP_RSTART) bbusy <= 1'b1;
                if (cur.op == OP_STOP)   bbusy <= 1'b0;
            end
            if (state == ST_RETIRE && !ptr_last) ptr <= ptr + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        busy         = (state != ST_IDLE);
        bus_busy     = bbusy;
        prim_req     = (state == ST_XFER);
        prim_op      = cur.op;
        prim_wdata   = wbyte;
        prim_ack_out = cur.ack_val;
        tx_pop       = (state == ST_LOAD) && (cur.op == OP_WRITE) && !tx_empty;
        rx_push      = ok_end && (cur.op == OP_READ);
        rx_wdata     = prim_rdata;
        done_set     = (state == ST_RETIRE) ||
                       ((state == ST_FETCH) && fetch_halt) ||
                       (ok_end && cur.op == OP_STOP);
        st_set           = '0;
        st_set[S_CMPL]   = ((state == ST_RETIRE) && ptr_last) ||
                           ((state == ST_FETCH) && fetch_halt) ||
                           (ok_end && cur.op == OP_STOP);
        st_set[S_ACKERR] = ok_end && ack_bad;
        st_set[S_TOUT]   = tout_hit;
        st_set[S_ARB]    = xfer_end && prim_arb_lost;
    end
endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top #(
    parameter int QDEPTH = 16,
    parameter int FDEPTH = 32,
    parameter int TO_W   = 16,
    localparam int QAW   = $clog2(QDEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_we,
    input  logic [QAW-1:0]  cmd_waddr,
    input  logic [31:0]     cmd_wdata,
    input  logic [QAW-1:0]  cmd_raddr,
    output logic [31:0]     cmd_rdata,
    input  logic            go,
    output logic            busy,
    output logic            bus_busy,
    input  logic            tx_push,
    input  logic [7:0]      tx_data,
    output logic            tx_full,
    input  logic            rx_pop,
    output logic [7:0]      rx_data,
    output logic            rx_empty,
    input  logic            tx_flush,
    input  logic            rx_flush,
    input  logic [TO_W-1:0] to_limit,
    input  logic [3:0]      int_ena,
    input  logic [3:0]      int_clr,
    output logic [3:0]      int_raw,
    output logic            irq,
    output logic            prim_req,
    output logic [2:0]      prim_op,
    output logic [7:0]      prim_wdata,
    output logic            prim_ack_out,
    input  logic            prim_done,
    input  logic [7:0]      prim_rdata,
    input  logic            prim_ack_in,
    input  logic            prim_arb_lost,
    input  logic            bus_stall
);
    logic [31:0]    seq_word;
    logic [QAW-1:0] ptr;
    logic           done_set;
    logic           tx_empty, tx_pop, rx_full, rx_push;
    logic [7:0]     tx_head, rx_wdata;
    logic [3:0]     st_set;

    i2cseq_cmdq #(.DEPTH(QDEPTH)) u_cmdq (
        .clk(clk), .rst_n(rst_n),
        .sw_we(cmd_we), .sw_waddr(cmd_waddr), .sw_wdata(cmd_wdata),
        .sw_raddr(cmd_raddr), .sw_rdata(cmd_rdata),
        .seq_raddr(ptr), .seq_rdata(seq_word),
        .done_set(done_set), .done_addr(ptr)
    );

    i2cseq_fifo #(.W(8), .DEPTH(FDEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(tx_push), .wdata(tx_data), .pop(tx_pop),
        .rdata(tx_head), .empty(tx_empty), .full(tx_full)
    );

    i2cseq_fifo #(.W(8), .DEPTH(FDEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
        .rdata(rx_data), .empty(rx_empty), .full(rx_full)
    );

    i2cseq_ctrl #(.QDEPTH(QDEPTH), .TO_W(TO_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .bus_busy(bus_busy),
        .cmd_word(seq_word), .ptr(ptr), .done_set(done_set),
        .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_wdata(rx_wdata),
        .to_limit(to_limit), .st_set(st_set),
        .prim_req(prim_req), .prim_op(prim_op), .prim_wdata(prim_wdata),
        .prim_ack_out(prim_ack_out), .prim_done(prim_done),
        .prim_rdata(prim_rdata), .prim_ack_in(prim_ack_in),
        .prim_arb_lost(prim_arb_lost), .bus_stall(bus_stall)
    );

    i2cseq_irq #(.N(4)) u_irq (
        .clk(clk), .rst_n(rst_n), .set(st_set), .clr(int_clr),
        .ena(int_ena), .raw(int_raw), .irq(irq)
    );
endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       bus_busy,
    input logic       prim_req,
    input logic [2:0] prim_op,
    input logic [7:0] prim_wdata,
    input logic       prim_done,
    input logic       prim_arb_lost,
    input logic       bus_stall,
    input logic [3:0] int_raw,
    input logic [3:0] int_clr
);
    p_req_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prim_req |-> busy);

    p_hold_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_req && !prim_done && !bus_stall) |=>
        (prim_req && $stable(prim_op) && $stable(prim_wdata)));

    p_req_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_req && prim_done) |=> !prim_req);

    p_start_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_req && prim_done && !prim_arb_lost && !bus_stall && prim_op == 3'd0)
        |=> bus_busy);

    p_stop_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_req && prim_done && !prim_arb_lost && !bus_stall && prim_op == 3'd3)
        |=> (!bus_busy && !busy && int_raw[0]));

    p_arb_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_req && prim_done && prim_arb_lost && !bus_stall)
        |=> (int_raw[3] && !busy));

    for (genvar i = 0; i < 4; i++) begin : g_sticky
        p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (int_raw[i] && !int_clr[i]) |=> int_raw[i]);
    end
endmodule

bind i2cseq_top i2cseq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .bus_busy(bus_busy),
    .prim_req(prim_req), .prim_op(prim_op), .prim_wdata(prim_wdata),
    .prim_done(prim_done), .prim_arb_lost(prim_arb_lost),
    .bus_stall(bus_stall), .int_raw(int_raw), .int_clr(int_clr)
);

// File: tb/test_i2cseq_top.sv
module test_i2cseq_top;
    localparam int CLK_PERIOD = 10;
    localparam int QD  = 16;
    localparam int FD  = 32;
    localparam int TOW = 16;

    logic clk, rst_n;
    logic cmd_we = 0;
    logic [3:0] cmd_waddr = 0, cmd_raddr = 0;
    logic [31:0] cmd_wdata = 0, cmd_rdata;
    logic go = 0, busy, bus_busy;
    logic tx_push = 0, tx_full, rx_pop = 0, rx_empty;
    logic [7:0] tx_data = 0, rx_data;
    logic tx_flush = 0, rx_flush = 0;
    logic [TOW-1:0] to_limit = 16'd50;
    logic [3:0] int_ena = 0, int_clr = 0, int_raw;
    logic irq, prim_req, prim_ack_out;
    logic [2:0] prim_op;
    logic [7:0] prim_wdata;
    logic prim_done = 0, prim_ack_in = 0, prim_arb_lost = 0, bus_stall = 0;
    logic [7:0] prim_rdata = 0;

    bit nack_mode = 0, arb_mode = 0;
    int n_chk = 0, n_fail = 0;
    int log_n = 0, rd_cnt = 0;
    logic [2:0] op_log [256];
    logic [7:0] wd_log [256];
    logic       ak_log [256];

    i2cseq_top #(.QDEPTH(QD), .FDEPTH(FD), .TO_W(TOW)) i_i2cseq_top (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_waddr(cmd_waddr),
        .cmd_wdata(cmd_wdata), .cmd_raddr(cmd_raddr), .cmd_rdata(cmd_rdata),
        .go(go), .busy(busy), .bus_busy(bus_busy), .tx_push(tx_push),
        .tx_data(tx_data), .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_empty(rx_empty), .tx_flush(tx_flush), .rx_flush(rx_flush),
        .to_limit(to_limit), .int_ena(int_ena), .int_clr(int_clr),
        .int_raw(int_raw), .irq(irq), .prim_req(prim_req), .prim_op(prim_op),
        .prim_wdata(prim_wdata), .prim_ack_out(prim_ack_out),
        .prim_done(prim_done), .prim_rdata(prim_rdata), .prim_ack_in(prim_ack_in),
        .prim_arb_lost(prim_arb_lost), .bus_stall(bus_stall)
    );

    initial begin
        clk = 0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    // Bit-engine model: answers a request after two cycles unless stalled
    initial begin
        int lat;
        lat = 0;
        forever begin
            @(negedge clk);
            if (prim_done) begin
                prim_done = 0;
                prim_arb_lost = 0;
            end else if (prim_req && !bus_stall) begin
                lat++;
                if (lat >= 2) begin
                    lat = 0;
                    if (log_n < 256) begin
                        op_log[log_n] = prim_op;
                        wd_log[log_n] = prim_wdata;
                        ak_log[log_n] = prim_ack_out;
                    end
                    log_n++;
                    prim_rdata = 8'h5A + 8'(rd_cnt);
                    if (prim_op == 3'd2) rd_cnt++;
                    prim_ack_in = nack_mode;
                    prim_arb_lost = arb_mode;
                    prim_done = 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input int op, input int cnt,
                                       input bit en, input bit ex, input bit val);
        logic [31:0] w;
        w = '0;
        w[7:0]   = cnt[7:0];
        w[8]     = en;
        w[9]     = ex;
        w[10]    = val;
        w[13:11] = op[2:0];
        return w;
    endfunction

    task automatic qwr(input int a, input logic [31:0] w);
        @(negedge clk);
        cmd_we = 1; cmd_waddr = a[3:0]; cmd_wdata = w;
        @(negedge clk);
        cmd_we = 0;
    endtask

    task automatic txp(input logic [7:0] d);
        @(negedge clk);
        tx_push = 1; tx_data = d;
        @(negedge clk);
        tx_push = 0;
    endtask

    task automatic pulse_go();
        @(negedge clk); go = 1;
        @(negedge clk); go = 0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while (busy && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic clr_all();
        @(negedge clk); int_clr = 4'hF;
        @(negedge clk); int_clr = 4'h0;
    endtask

    function automatic bit done_of(input int a);
        return i_i2cseq_top.cmd_rdata[31] & (cmd_raddr == a[3:0]);
    endfunction

    task automatic get_done(input int a, output bit d);
        cmd_raddr = a[3:0];
        #1;
        d = cmd_rdata[31];
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy == 0 && bus_busy == 0 && prim_req == 0, "R1 idle flags",
            {busy, bus_busy, prim_req}, 0);
        chk(int_raw == 0 && irq == 0, "R1 status", {int_raw, irq}, 0);
        chk(rx_empty == 1 && tx_full == 0, "R1 fifos", {rx_empty, tx_full}, 2);
    endtask

    task automatic t_write();
        int base;
        bit d;
        clr_all();
        int_ena = 4'h1;
        qwr(0, cw(0, 0, 0, 0, 0));
        qwr(1, cw(1, 3, 1, 0, 0));
        qwr(2, cw(1, 0, 0, 0, 0));
        qwr(3, cw(3, 0, 0, 0, 0));
        txp(8'hA1); txp(8'hB2); txp(8'hC3);
        base = log_n;
        @(negedge clk); go = 1;
        chk(busy == 0, "R2 busy before edge", busy, 0);
        @(negedge clk); go = 0;
        chk(busy == 1, "R2 busy one edge after go", busy, 1);
        while (log_n < base + 2) @(negedge clk);
        pulse_go();
        wait_idle();
        chk(log_n - base == 5, "R2 single pass, extra go ignored", log_n - base, 5);
        chk(op_log[base] == 3'd0, "R3 start opcode", op_log[base], 0);
        chk(op_log[base+1] == 3'd1 && op_log[base+3] == 3'd1, "R3 write opcode",
            op_log[base+3], 1);
        chk(op_log[base+4] == 3'd3, "R3 stop opcode", op_log[base+4], 3);
        chk(wd_log[base+1] == 8'hA1, "R4 byte 0", wd_log[base+1], 8'hA1);
        chk(wd_log[base+2] == 8'hB2, "R4 byte 1", wd_log[base+2], 8'hB2);
        chk(wd_log[base+3] == 8'hC3, "R4 byte 2", wd_log[base+3], 8'hC3);
        for (int i = 0; i < 4; i++) begin
            get_done(i, d);
            chk(d == 1, "R8 done flag set", d, 1);
        end
        chk(bus_busy == 0, "R9 stop clears bus_busy", bus_busy, 0);
        chk(int_raw == 4'b0001 && irq == 1, "R12 complete raised", {int_raw, irq}, 5'b00011);
    endtask

    task automatic t_read();
        int base, rb;
        bit d;
        clr_all();
        qwr(0, cw(0, 0, 0, 0, 0));
        qwr(1, cw(2, 2, 0, 0, 0));
        qwr(2, cw(2, 1, 0, 0, 1));
        qwr(3, cw(4, 0, 0, 0, 0));
        base = log_n;
        rb = rd_cnt;
        pulse_go();
        wait_idle();
        chk(log_n - base == 4, "R7 no stop primitive after end", log_n - base, 4);
        chk(op_log[base+1] == 3'd2 && op_log[base+3] == 3'd2, "R6 read opcode",
            op_log[base+3], 2);
        chk(ak_log[base+1] == 0 && ak_log[base+2] == 0, "R6 ack sent", ak_log[base+2], 0);
        chk(ak_log[base+3] == 1, "R6 nack on final byte", ak_log[base+3], 1);
        for (int i = 0; i < 3; i++) begin
            chk(rx_data == 8'(8'h5A + rb + i), "R6 rx byte order", rx_data, 8'(8'h5A + rb + i));
            rx_pop = 1;
            @(negedge clk);
            rx_pop = 0;
        end
        chk(rx_empty == 1, "R6 rx drained", rx_empty, 1);
        get_done(3, d);
        chk(d == 1, "R7 end entry done", d, 1);
        chk(int_raw[0] == 1, "R7 end completes", int_raw, 1);
        chk(bus_busy == 1, "R9 start sets bus_busy, end keeps it", bus_busy, 1);
        qwr(0, cw(3, 0, 0, 0, 0));
        base = log_n;
        pulse_go();
        wait_idle();
        chk(log_n - base == 1 && op_log[base] == 3'd3, "R7 restart from entry 0",
            op_log[base], 3);
        chk(bus_busy == 0, "R9 stop clears bus_busy", bus_busy, 0);
    endtask

    task automatic t_ackerr();
        int base;
        bit d;
        clr_all();
        qwr(0, cw(1, 2, 1, 0, 0));
        qwr(1, cw(4, 0, 0, 0, 0));
        txp(8'h11); txp(8'h22);
        nack_mode = 1;
        base = log_n;
        pulse_go();
        wait_idle();
        chk(int_raw[1] == 1, "R5 ack error raised", int_raw, 2);
        chk(int_raw[0] == 0, "R5 no completion on ack error", int_raw, 2);
        chk(log_n - base == 1, "R5 halts after nacked byte", log_n - base, 1);
        get_done(0, d);
        chk(d == 0, "R5 failed entry not done", d, 0);
        @(negedge clk); tx_flush = 1;
        @(negedge clk); tx_flush = 0;
        clr_all();
        qwr(0, cw(1, 2, 0, 0, 0));
        txp(8'h33); txp(8'h44);
        base = log_n;
        pulse_go();
        wait_idle();
        nack_mode = 0;
        chk(int_raw == 4'b0001, "R5 nack ignored without check", int_raw, 1);
        chk(log_n - base == 2 && wd_log[base+1] == 8'h44, "R5 both bytes sent",
            wd_log[base+1], 8'h44);
        get_done(0, d);
        chk(d == 1, "R5 entry done without check", d, 1);
    endtask

    task automatic t_timeout();
        clr_all();
        to_limit = 16'd5;
        qwr(0, cw(0, 0, 0, 0, 0));
        qwr(1, cw(4, 0, 0, 0, 0));
        bus_stall = 1;
        @(negedge clk); go = 1;
        @(negedge clk); go = 0;
        repeat (5) @(negedge clk);
        chk(int_raw[2] == 0 && busy == 1, "R10 not yet timed out", {int_raw[2], busy}, 1);
        @(negedge clk);
        chk(int_raw[2] == 1 && busy == 0, "R10 timeout at limit", {int_raw[2], busy}, 2);
        bus_stall = 0;
        clr_all();
        to_limit = 16'd0;
        qwr(0, cw(1, 1, 0, 0, 0));
        pulse_go();
        repeat (30) @(negedge clk);
        chk(busy == 1 && prim_req == 0, "R4 empty TX holds", {busy, prim_req}, 2);
        chk(int_raw[2] == 0, "R10 limit zero disables", int_raw, 0);
        txp(8'h5E);
        wait_idle();
        chk(wd_log[log_n-1] == 8'h5E && int_raw == 4'b0001, "R4 resumes after push",
            wd_log[log_n-1], 8'h5E);
        to_limit = 16'd50;
    endtask

    task automatic t_arb();
        bit d;
        clr_all();
        qwr(0, cw(0, 0, 0, 0, 0));
        qwr(1, cw(4, 0, 0, 0, 0));
        arb_mode = 1;
        pulse_go();
        wait_idle();
        arb_mode = 0;
        chk(int_raw == 4'b1000, "R11 arbitration lost", int_raw, 8);
        get_done(0, d);
        chk(d == 0 && busy == 0, "R11 halted, entry not done", {d, busy}, 0);
    endtask

    task automatic t_status();
        @(negedge clk); int_ena = 4'b0001;
        @(negedge clk);
        chk(irq == 0, "R12 masked", irq, 0);
        int_ena = 4'b1000;
        #1;
        chk(irq == 1, "R12 enabled", irq, 1);
        repeat (3) @(negedge clk);
        chk(int_raw == 4'b1000, "R12 sticky", int_raw, 8);
        int_clr = 4'b1000;
        @(negedge clk);
        int_clr = 0;
        chk(int_raw == 0 && irq == 0, "R12 clear next edge", {int_raw, irq}, 0);
    endtask

    task automatic t_flush();
        clr_all();
        txp(8'h01); txp(8'h02);
        qwr(0, cw(2, 1, 0, 0, 1));
        qwr(1, cw(4, 0, 0, 0, 0));
        pulse_go();
        wait_idle();
        chk(rx_empty == 0, "R13 rx holds a byte", rx_empty, 0);
        @(negedge clk); tx_flush = 1;
        @(negedge clk); tx_flush = 0;
        chk(rx_empty == 0, "R13 tx flush leaves rx", rx_empty, 0);
        qwr(0, cw(1, 1, 0, 0, 0));
        txp(8'h77);
        pulse_go();
        wait_idle();
        chk(wd_log[log_n-1] == 8'h77, "R13 tx flushed", wd_log[log_n-1], 8'h77);
        @(negedge clk); rx_flush = 1;
        @(negedge clk); rx_flush = 0;
        chk(rx_empty == 1, "R13 rx flushed", rx_empty, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_write();
        t_read();
        t_ackerr();
        t_timeout();
        t_arb();
        t_status();
        t_flush();
        repeat (2) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule